// File: doc/BRIEF.md
# Vector Length Control Unit

This block is the execute-stage logic for an instruction that sets the vector length. It keeps three pieces of architectural state: a maximum vector length (MVL), the active vector length (VL) and a vertical-first mode flag. When a decoded instruction arrives with `op_valid` high, the unit works out the new MVL and VL from the instruction fields and operands. It also produces the value for the destination register and, if the record bit is set, a 4-bit condition field. All of these outputs are driven combinationally in the same cycle as the strobe. The state registers take their new values at the following clock edge.

There are three possible sources for a requested VL. A destination index of zero picks the loop counter. A nonzero destination index with a nonzero source index picks the source operand. Otherwise the 7-bit immediate is used. The immediate is stored plus one, so it covers lengths 1 to 128. A request larger than MVL is clamped to MVL. The clamp also sets a sticky overflow bit, which shows up in the condition field. With every control bit clear, the instruction only reads back the current VL.

Top module: `vlen_ctl`

## Requirements
- R1: When MVL or VL is taken from the immediate, the value stored is the 7-bit immediate plus one. Encoded 0 gives 1 and encoded 127 gives 128.
- R2: MVL is written from the immediate only when `set_mvl` is high. VL is written only when `set_vl` is high. A register whose enable is low keeps its value.
- R3: With both `set_mvl` and `set_vl` high and the immediate as VL source, MVL and VL both receive the same value, the immediate plus one.
- R4: A requested VL larger than the limit causes VL to be written with the limit. The limit is the MVL written by the same instruction, or the held MVL if the instruction does not write MVL.
- R5: A clamp sets a sticky overflow flag that only reset clears. Condition bit 0 (SO) equals the sticky flag OR'ed with a clamp in the current instruction.
- R6: When `rec` is high, `cr_we` is high and `cr_field` describes the resulting VL, even when `rt_idx` is 0. The bits are: bit 3 (LT) = 0, bit 2 (GT) = 1 if VL is nonzero, bit 1 (EQ) = 1 if VL is zero. When `rec` is low, `cr_we` is low.
- R7: When `rt_idx` is 0, the requested VL is `ctr_val`.
- R8: When `rt_idx` is nonzero, the requested VL is `ra_val` if `ra_idx` is nonzero, and the immediate plus one if `ra_idx` is zero.
- R9: With `set_vl`, `set_mvl` and `set_vert` all low, the unit returns the current VL on `rt_data` and leaves MVL, VL and the mode flag unchanged.
- R10: The vertical-first flag takes `set_vert` only when `set_vl` or `set_mvl` is also high. Otherwise it keeps its value.
- R11: After reset, MVL is 0, VL is 0, the mode flag is 0 and the overflow flag is clear.
- R12: `rt_we` is high exactly when `op_valid` is high and `rt_idx` is nonzero. `rt_data` is then the resulting VL, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Decoded instruction present this cycle |
| imm | input | 7 | Biased length immediate |
| set_vl | input | 1 | Enable VL write |
| set_mvl | input | 1 | Enable MVL write |
| set_vert | input | 1 | Requested vertical-first mode |
| rt_idx | input | 5 | Destination register index (0 selects counter source) |
| ra_idx | input | 5 | Source register index |
| rec | input | 1 | Record condition field |
| ra_val | input | 64 | Source operand value |
| ctr_val | input | 64 | Loop counter value |
| rt_we | output | 1 | Destination register write enable |
| rt_data | output | 64 | Destination register value (resulting VL) |
| cr_we | output | 1 | Condition field write enable |
| cr_field | output | 4 | Condition field {LT, GT, EQ, SO} |
| mvl_q | output | 8 | Current maximum vector length |
| vl_q | output | 8 | Current vector length |
| vert_q | output | 1 | Vertical-first mode flag |

## Verification
The assertions assume the instruction fields are stable and already decoded during any cycle in which `op_valid` is high. They also assume the strobe lasts for a single cycle per instruction, so that comparing state one cycle later refers to exactly one update. The stimulus drives every field at the falling edge, raises `op_valid` for one cycle per instruction, and drops it before the next. Operand values are kept 64 bits wide, so counter and operand requests far above 128 reach the clamp without being truncated.

// File: rtl/vlen_pkg.sv
package vlen_pkg;
   localparam int CR_LT = 3;
   localparam int CR_GT = 2;
   localparam int CR_EQ = 1;
   localparam int CR_SO = 0;
   localparam int CR_W  = 4;
endpackage

// File: rtl/vlen_src_sel.sv
// Chooses where the requested vector length comes from.
module vlen_src_sel #(
   parameter int IMM_W     = 7,
   parameter int XLEN      = 64,
   parameter int REG_W     = 5,
   parameter bit RA_SOURCE = 1'b1
) (
   input  logic [REG_W-1:0] rt_idx,
   input  logic [REG_W-1:0] ra_idx,
   input  logic [IMM_W-1:0] imm,
   input  logic [XLEN-1:0]  ra_val,
   input  logic [XLEN-1:0]  ctr_val,
   output logic [XLEN-1:0]  req_len
);
   logic [XLEN-1:0] imm_len;
   logic            use_ctr;
   logic            use_ra;

   assign imm_len = XLEN'(imm) + XLEN'(1);
   assign use_ctr = (rt_idx == '0);

   generate
      if (RA_SOURCE) begin : g_ra_src
         assign use_ra = (ra_idx != '0);
      end else begin : g_no_ra_src
         logic unused_ra;
         assign unused_ra = ^{ra_idx, ra_val};
         assign use_ra    = 1'b0;
      end
   endgenerate

   always_comb begin
      if (use_ctr)     req_len = ctr_val;
      else if (use_ra) req_len = ra_val;
      else             req_len = imm_len;
   end
endmodule

// File: rtl/vlen_clamp.sv
// Limits a wide request to the maximum length and flags the clamp.
module vlen_clamp #(
   parameter int XLEN  = 64,
   parameter int LEN_W = 8
) (
   input  logic [XLEN-1:0]  req_len,
   input  logic [LEN_W-1:0] limit,
   output logic [LEN_W-1:0] len_out,
   output logic             over
);
   assign over    = req_len > XLEN'(limit);
   assign len_out = over ? limit : req_len[LEN_W-1:0];
endmodule

// File: rtl/vlen_cr_gen.sv
// Builds the condition field from the resulting length.
module vlen_cr_gen
   import vlen_pkg::*;
#(
   parameter int LEN_W = 8
) (
   input  logic [LEN_W-1:0] vl,
   input  logic             so,
   output logic [CR_W-1:0]  cr
);
   always_comb begin
      cr        = '0;
      cr[CR_LT] = 1'b0;
      cr[CR_GT] = (vl != '0);
      cr[CR_EQ] = (vl == '0);
      cr[CR_SO] = so;
   end
endmodule

// File: rtl/vlen_ctl.sv
module vlen_ctl
   import vlen_pkg::*;
#(
   parameter int IMM_W     = 7,
   parameter int LEN_W     = 8,
   parameter int XLEN      = 64,
   parameter int REG_W     = 5,
   parameter bit RA_SOURCE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_valid,
   input  logic [IMM_W-1:0] imm,
   input  logic             set_vl,
   input  logic             set_mvl,
   input  logic             set_vert,
   input  logic [REG_W-1:0] rt_idx,
   input  logic [REG_W-1:0] ra_idx,
   input  logic             rec,
   input  logic [XLEN-1:0]  ra_val,
   input  logic [XLEN-1:0]  ctr_val,
   output logic             rt_we,
   output logic [XLEN-1:0]  rt_data,
   output logic             cr_we,
   output logic [CR_W-1:0]  cr_field,
   output logic [LEN_W-1:0] mvl_q,
   output logic [LEN_W-1:0] vl_q,
   output logic             vert_q
);
   localparam int MAX_LEN = 1 << IMM_W;

   generate
      if (LEN_W < IMM_W + 1) begin : g_bad_len
         $error("LEN_W too narrow for biased immediate");
      end
      if (XLEN < LEN_W) begin : g_bad_xlen
         $error("XLEN narrower than LEN_W");
      end
      if (MAX_LEN > (1 << LEN_W) - 1) begin : g_bad_max
         $error("LEN_W cannot hold maximum length");
      end
   endgenerate

   logic [XLEN-1:0]  req_len;
   logic [LEN_W-1:0] imm_len;
   logic [LEN_W-1:0] mvl_next;
   logic [LEN_W-1:0] clamp_len;
   logic             clamp_over;
   logic [LEN_W-1:0] vl_next;
   logic             clamp_hit;
   logic             so_q;
   logic             touch;

   vlen_src_sel #(
      .IMM_W(IMM_W), .XLEN(XLEN), .REG_W(REG_W), .RA_SOURCE(RA_SOURCE)
   ) u_src (
      .rt_idx (rt_idx),
      .ra_idx (ra_idx),
      .imm    (imm),
      .ra_val (ra_val),
      .ctr_val(ctr_val),
      .req_len(req_len)
   );

   assign imm_len  = LEN_W'(imm) + LEN_W'(1);
   assign mvl_next = set_mvl ? imm_len : mvl_q;

   vlen_clamp #(.XLEN(XLEN), .LEN_W(LEN_W)) u_clamp (
      .req_len(req_len),
      .limit  (mvl_next),
      .len_out(clamp_len),
      .over   (clamp_over)
   );

   assign vl_next   = set_vl ? clamp_len : vl_q;
   assign clamp_hit = set_vl & clamp_over;
   assign touch     = set_vl | set_mvl;

   vlen_cr_gen #(.LEN_W(LEN_W)) u_cr (
      .vl(vl_next),
      .so(so_q | clamp_hit),
      .cr(cr_field)
   );

   assign rt_we   = op_valid & (rt_idx != '0);
   assign rt_data = XLEN'(vl_next);
   assign cr_we   = op_valid & rec;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mvl_q  <= '0;
         vl_q   <= '0;
         vert_q <= 1'b0;
         so_q   <= 1'b0;
      end else if (op_valid) begin
         mvl_q <= mvl_next;
         vl_q  <= vl_next;
         if (touch)     vert_q <= set_vert;
         if (clamp_hit) so_q   <= 1'b1;
      end
   end

   AST_IMM_BIAS: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && set_mvl) |=> (mvl_q == LEN_W'($past(imm)) + LEN_W'(1))); // R1
   AST_VL_WITHIN_MVL: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && set_vl) |=> (vl_q <= mvl_q)); // R4
   AST_CR_ONE_OF: assert property (@(posedge clk) disable iff (!rst_n)
      cr_we |-> ($countones(cr_field[CR_GT:CR_EQ]) == 1 && !cr_field[CR_LT])); // R6
   AST_GET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !set_vl && !set_mvl && !set_vert)
         |=> ($stable(vl_q) && $stable(mvl_q) && $stable(vert_q))); // R9
   AST_VERT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !set_vl && !set_mvl) |=> $stable(vert_q)); // R10
   AST_SO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && rec && cr_field[CR_SO]) |=> (!op_valid || !rec || cr_field[CR_SO])); // R5
endmodule

// File: tb/vlen_ctl_test.sv
module vlen_ctl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [6:0]  imm = '0;
   logic        set_vl = 1'b0, set_mvl = 1'b0, set_vert = 1'b0;
   logic [4:0]  rt_idx = '0, ra_idx = '0;
   logic        rec = 1'b0;
   logic [63:0] ra_val = '0, ctr_val = '0;
   logic        rt_we, cr_we, vert_q;
   logic [63:0] rt_data;
   logic [3:0]  cr_field;
   logic [7:0]  mvl_q, vl_q;

   int n_tests = 0;
   int n_fail  = 0;

   logic [7:0] m_mvl, m_vl;
   logic       m_vf, m_so;

   vlen_ctl uut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .imm(imm),
      .set_vl(set_vl), .set_mvl(set_mvl), .set_vert(set_vert),
      .rt_idx(rt_idx), .ra_idx(ra_idx), .rec(rec),
      .ra_val(ra_val), .ctr_val(ctr_val),
      .rt_we(rt_we), .rt_data(rt_data), .cr_we(cr_we), .cr_field(cr_field),
      .mvl_q(mvl_q), .vl_q(vl_q), .vert_q(vert_q)
   );

   always #2 clk = ~clk;

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic exec(input bit vs, input bit ms, input bit vf, input int rt,
                       input int ra, input bit rc, input int im,
                       input logic [63:0] rav, input logic [63:0] ctr,
                       input string req);
      logic [7:0]  nm, nv;
      logic [63:0] rq;
      bit          ov;
      nm = ms ? 8'(im + 1) : m_mvl;
      if (rt == 0)      rq = ctr;
      else if (ra != 0) rq = rav;
      else              rq = 64'(im + 1);
      ov = 1'b0;
      nv = m_vl;
      if (vs) begin
         if (rq > 64'(nm)) begin nv = nm; ov = 1'b1; end
         else nv = rq[7:0];
      end
      @(negedge clk);
      op_valid = 1'b1; set_vl = vs; set_mvl = ms; set_vert = vf;
      rt_idx = 5'(rt); ra_idx = 5'(ra); rec = rc; imm = 7'(im);
      ra_val = rav; ctr_val = ctr;
      #1;
      chk(rt_we == (rt != 0), {req, " R12 rt_we"}, 64'(rt_we), 64'(rt != 0));
      if (rt != 0) chk(rt_data == 64'(nv), {req, " R12 rt_data"}, rt_data, 64'(nv));
      chk(cr_we == rc, {req, " R6 cr_we"}, 64'(cr_we), 64'(rc));
      if (rc) chk(cr_field == {1'b0, nv != 0, nv == 0, m_so | ov},
                  {req, " R5/R6 cr"}, 64'(cr_field),
                  64'({1'b0, nv != 0, nv == 0, m_so | ov}));
      @(negedge clk);
      op_valid = 1'b0; set_vl = 0; set_mvl = 0; set_vert = 0; rec = 0;
      m_mvl = nm; m_vl = nv; m_so = m_so | ov;
      if (vs || ms) m_vf = vf;
      #1;
      chk(mvl_q == m_mvl, {req, " mvl"}, 64'(mvl_q), 64'(m_mvl));
      chk(vl_q == m_vl, {req, " vl"}, 64'(vl_q), 64'(m_vl));
      chk(vert_q == m_vf, {req, " vert"}, 64'(vert_q), 64'(m_vf));
   endtask

   task automatic t_reset;
      chk(mvl_q == 0, "R11 mvl", 64'(mvl_q), 0);
      chk(vl_q == 0, "R11 vl", 64'(vl_q), 0);
      chk(vert_q == 0, "R11 vert", 64'(vert_q), 0);
      // clamp against zero MVL shows the fresh overflow, EQ set
      exec(1, 0, 0, 3, 0, 1, 5, 0, 0, "R11 R4 zero-mvl clamp");
   endtask

   task automatic t_bias;
      exec(0, 1, 0, 3, 0, 0, 0, 0, 0, "R1 imm 0");
      exec(0, 1, 0, 3, 0, 0, 127, 0, 0, "R1 imm 127");
      exec(1, 0, 0, 3, 0, 1, 0, 0, 0, "R1 R2 vl only");
   endtask

   task automatic t_both;
      exec(1, 1, 0, 4, 0, 1, 7, 0, 0, "R3 both 8");
   endtask

   task automatic t_clamp;
      exec(0, 1, 0, 4, 0, 0, 3, 0, 0, "R2 mvl 4");
      exec(1, 0, 0, 4, 0, 1, 9, 0, 0, "R4 imm clamp");
      exec(1, 0, 0, 4, 0, 1, 1, 0, 0, "R5 sticky so");
   endtask

   task automatic t_ctr;
      exec(0, 1, 0, 4, 0, 0, 63, 0, 0, "R2 mvl 64");
      exec(1, 0, 0, 0, 0, 1, 0, 0, 2, "R7 ctr 2 rt0");
      exec(1, 0, 0, 0, 0, 1, 0, 0, 0, "R7 R6 ctr 0 eq");
      exec(1, 0, 0, 0, 0, 1, 0, 0, 64'd1000, "R7 R4 ctr clamp");
      exec(1, 1, 0, 0, 0, 1, 15, 0, 64'd40, "R4 new mvl limit");
   endtask

   task automatic t_ra;
      exec(1, 0, 0, 6, 9, 1, 100, 64'd3, 64'd50, "R8 ra source");
      exec(1, 0, 0, 6, 0, 0, 4, 64'd60, 64'd50, "R8 imm source");
   endtask

   task automatic t_get;
      exec(0, 0, 0, 7, 0, 1, 99, 64'd77, 64'd77, "R9 getvl");
   endtask

   task automatic t_vert;
      exec(1, 0, 1, 2, 0, 0, 1, 0, 0, "R10 vf set");
      exec(0, 0, 0, 2, 0, 0, 1, 0, 0, "R10 vf kept");
      exec(0, 0, 1, 2, 0, 0, 1, 0, 0, "R10 vf alone ignored");
      exec(0, 1, 0, 2, 0, 0, 1, 0, 0, "R10 vf cleared with ms");
   endtask

   initial begin : watchdog
      #400000;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      m_mvl = 0; m_vl = 0; m_vf = 0; m_so = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      t_reset();
      t_bias();
      t_both();
      t_clamp();
      t_ctr();
      t_ra();
      t_get();
      t_vert();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule